// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Register Bank

This block holds the output codes for four digital-to-analog channels. A host writes it one byte at a time over an 8-bit data bus, with a 4-bit register offset and a write strobe. Each channel has two registers. The staging register collects the bytes the host writes. The output register drives the channel's 12-bit parallel code, which the block presents on its output port.

A single update-style bit sits in a control register and picks how staged codes reach the outputs. In immediate style, writing a channel's upper byte updates that channel's output at once. In simultaneous style, byte writes only fill the staging registers. All four outputs then take their staged codes together when software moves the bit from 0 back to 1. This lets several channels change in phase, and it keeps any channel from showing a half-written code.

Codes are left-justified. For bipolar ranges they are offset binary, so a set MSB means a positive value. The block passes the code through without changing it.

Top module: `dac_update_bank`

## Requirements
- R1: Channel n (n = 0..3) has its lower-byte register at offset 8+2n and its upper-byte register at offset 9+2n. A write to any offset other than these eight and the control offset 2 changes no output.
- R2: A channel's 12-bit code is left-justified. Code bits 11..4 come from the upper byte. Code bits 3..0 come from bits 7..4 of the lower byte. Bits 3..0 of the lower byte are ignored.
- R3: A lower-byte write never changes any output register by itself.
- R4: With the update-style bit at 0, an upper-byte write loads that channel's output with {upper byte, staged lower nibble}. The new value is visible from the clock edge that accepts the write, and no other channel's output changes.
- R5: With the update-style bit at 1, upper-byte and lower-byte writes only load the staging registers, and every output stays unchanged.
- R6: The update-style bit is bit 7 of the control register at offset 2. A control write that moves the bit from 0 to 1 makes all four outputs load their staged codes at the next clock edge, one cycle after the write edge. The outputs do not change at the write edge itself.
- R7: A control write of 1 while the bit is already 1 causes no transfer. A control write that moves the bit from 1 to 0 causes no transfer.
- R8: Synchronous active-high reset clears all staging registers, all output registers and the update-style bit to zero.
- R9: A code with its MSB set (offset-binary positive, such as 0x800) passes to the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, sampled on the rising edge |
| wr_offs | input | 4 | Register offset of the write |
| wr_data | input | 8 | Write data byte |
| dac_code | output | 48 | Four 12-bit output codes, channel n at bits 12n+11..12n |

## Verification
Immediate-style writes use a different pattern in each channel. This shows whether the offset decode and the byte-to-code placement go to the right channel and bit positions. It also shows whether lower-byte writes are kept apart from output loads.

Lower bytes with noise in bits 3..0 show whether the ignored bits ever leak into the code. Stray writes to unused offsets show whether those offsets have any effect.

In simultaneous style, the outputs are checked one cycle after the 0-to-1 control write and again one cycle later. This separates a correct delayed transfer from an early transfer or a missing one. Repeated writes of 1, and writes back to 0, show whether the block reacts only to the rising transition and not to the level of the bit.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef enum logic {
    UPD_IMMEDIATE    = 1'b0,
    UPD_SIMULTANEOUS = 1'b1
  } upd_style_e;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode #(
  parameter int NUM_CH    = 4,
  parameter int OFFS_W    = 4,
  parameter int BASE_OFFS = 8,
  parameter int CTRL_OFFS = 2
) (
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_offs,
  output logic [NUM_CH-1:0] lo_wr,
  output logic [NUM_CH-1:0] hi_wr,
  output logic              ctrl_wr
);
  // Each channel owns a pair of offsets: lower byte first, upper byte second.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    localparam int LO_OFFS = BASE_OFFS + 2*g;
    localparam int HI_OFFS = LO_OFFS + 1;
    assign lo_wr[g] = wr_en && (wr_offs == OFFS_W'(LO_OFFS));
    assign hi_wr[g] = wr_en && (wr_offs == OFFS_W'(HI_OFFS));
  end
  assign ctrl_wr = wr_en && (wr_offs == OFFS_W'(CTRL_OFFS));
endmodule

// File: rtl/dac_sync_ctl.sv
module dac_sync_ctl
  import dac_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic       style_in,
  output upd_style_e style_q,
  output logic       xfer_q
);
  // The transfer pulse is registered, so the outputs load on the edge after the write.
  always_ff @(posedge clk) begin
    if (rst) begin
      style_q <= UPD_IMMEDIATE;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= ctrl_wr && style_in && (style_q == UPD_IMMEDIATE);
      if (ctrl_wr) style_q <= upd_style_e'(style_in);
    end
  end

  // R6: a transfer pulse is only raised by a 0-to-1 control write.
  p_xfer_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_q |-> ($past(ctrl_wr) && $past(style_in) && $past(style_q) == UPD_IMMEDIATE));

  // R7: writing 1 while the bit is already 1 gives no transfer.
  p_no_xfer_when_set_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && style_q == UPD_SIMULTANEOUS) |=> !xfer_q);
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  upd_style_e        style,
  input  logic              xfer,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code_q
);
  localparam int LO_W = CODE_W - BUS_W;

  logic [BUS_W-1:0] stage_hi;
  logic [LO_W-1:0]  stage_lo;

  // Staging registers: the lower byte keeps only its upper LO_W bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi <= '0;
      stage_lo <= '0;
    end else begin
      if (lo_wr) stage_lo <= wr_data[BUS_W-1 -: LO_W];
      if (hi_wr) stage_hi <= wr_data;
    end
  end

  // Output register: a broadcast transfer, or an immediate load on an upper-byte write.
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (xfer) begin
      code_q <= {stage_hi, stage_lo};
    end else if (hi_wr && style == UPD_IMMEDIATE) begin
      code_q <= {wr_data, stage_lo};
    end
  end

  // R3: a lower-byte write alone leaves the output untouched.
  p_lo_keeps_out_r3: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !xfer) |=> $stable(code_q));

  // R4: in immediate style the upper code bits follow the written byte.
  p_hi_immediate_r4: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && style == UPD_IMMEDIATE && !xfer) |=> code_q[CODE_W-1 -: BUS_W] == $past(wr_data));

  // R5: in simultaneous style the output holds until a transfer.
  p_hold_in_sync_r5: assert property (@(posedge clk) disable iff (rst)
    (style == UPD_SIMULTANEOUS && !xfer) |=> $stable(code_q));

  // R8: reset clears the output register.
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> code_q == '0);
endmodule

// File: rtl/dac_update_bank.sv
module dac_update_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CODE_W    = 12,
  parameter int BUS_W     = 8,
  parameter int OFFS_W    = 4,
  parameter int BASE_OFFS = 8,
  parameter int CTRL_OFFS = 2,
  parameter int STYLE_BIT = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [OFFS_W-1:0]        wr_offs,
  input  logic [BUS_W-1:0]         wr_data,
  output logic [NUM_CH*CODE_W-1:0] dac_code
);
  logic [NUM_CH-1:0] lo_wr;
  logic [NUM_CH-1:0] hi_wr;
  logic              ctrl_wr;
  upd_style_e        style_q;
  logic              xfer_q;

  dac_wr_decode #(
    .NUM_CH(NUM_CH), .OFFS_W(OFFS_W), .BASE_OFFS(BASE_OFFS), .CTRL_OFFS(CTRL_OFFS)
  ) u_dec (
    .wr_en(wr_en), .wr_offs(wr_offs), .lo_wr(lo_wr), .hi_wr(hi_wr), .ctrl_wr(ctrl_wr)
  );

  dac_sync_ctl u_sync (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .style_in(wr_data[STYLE_BIT]),
    .style_q(style_q), .xfer_q(xfer_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_ch (
      .clk(clk), .rst(rst), .lo_wr(lo_wr[g]), .hi_wr(hi_wr[g]),
      .style(style_q), .xfer(xfer_q), .wr_data(wr_data),
      .code_q(dac_code[g*CODE_W +: CODE_W])
    );
  end

  // R1: a single write strobe reaches at most one register.
  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lo_wr, hi_wr, ctrl_wr}));
endmodule

// File: tb/dac_update_bank_tb.sv
module dac_update_bank_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_offs = '0;
  logic [7:0]    wr_data = '0;
  logic [NCH*CW-1:0] dac_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0]    m_hi   [NCH];
  logic [3:0]    m_lo   [NCH];
  logic [CW-1:0] m_out  [NCH];
  bit            m_style;

  always #5 clk = ~clk;

  dac_update_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_offs(wr_offs),
    .wr_data(wr_data), .dac_code(dac_code)
  );

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      n_checks++;
      if (dac_code[c*CW +: CW] !== m_out[c]) begin
        n_fail++;
        $display("FAIL %s ch%0d actual=%03h expected=%03h", tag, c, dac_code[c*CW +: CW], m_out[c]);
      end
    end
  endtask

  // One byte write; the model is updated from the requirements, then outputs are checked.
  task automatic wr(input logic [3:0] offs, input logic [7:0] data, input string tag);
    bit rise;
    @(negedge clk);
    wr_en = 1'b1; wr_offs = offs; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    rise = 0;
    if (offs >= 8) begin
      int c = (offs - 8) / 2;
      if (offs[0] == 1'b0) m_lo[c] = data[7:4];
      else begin
        m_hi[c] = data;
        if (!m_style) m_out[c] = {m_hi[c], m_lo[c]};
      end
    end else if (offs == 2) begin
      rise = data[7] && !m_style;
      m_style = data[7];
    end
    check_all(tag);
    if (rise) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) m_out[c] = {m_hi[c], m_lo[c]};
      check_all({tag, " after transfer"});
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) begin m_hi[c] = '0; m_lo[c] = '0; m_out[c] = '0; end
    m_style = 0;
    check_all("R8 reset state");
  endtask

  task automatic t_immediate();
    wr(4'd8,  8'hA5, "R3 low write ch0");
    wr(4'd9,  8'h3C, "R4 high write ch0");
    wr(4'd10, 8'h70, "R3 low write ch1");
    wr(4'd11, 8'hE1, "R4 high write ch1");
    wr(4'd12, 8'h2F, "R2 low nibble ignored ch2");
    wr(4'd13, 8'h80, "R9 offset-binary MSB ch2");
    wr(4'd14, 8'hFF, "R2 low byte all ones ch3");
    wr(4'd15, 8'h01, "R4 high write ch3");
    wr(4'd12, 8'h50, "R3 restage ch2 without update");
  endtask

  task automatic t_stray();
    wr(4'd0, 8'hFF, "R1 stray offset 0");
    wr(4'd1, 8'hFF, "R1 stray offset 1");
    wr(4'd3, 8'hFF, "R1 stray offset 3");
    wr(4'd7, 8'hFF, "R1 stray offset 7");
  endtask

  task automatic t_sync();
    wr(4'd2,  8'h80, "R6 style set to simultaneous");
    wr(4'd8,  8'h10, "R5 staged low ch0");
    wr(4'd9,  8'h99, "R5 staged high ch0");
    wr(4'd11, 8'h44, "R5 staged high ch1");
    wr(4'd15, 8'hC3, "R5 staged high ch3");
    wr(4'd2,  8'hFF, "R7 rewrite of 1 no transfer");
    wr(4'd2,  8'h7F, "R7 1-to-0 no transfer");
    wr(4'd2,  8'h80, "R6 0-to-1 transfer");
  endtask

  task automatic t_sync_again();
    wr(4'd13, 8'h5A, "R5 staged high ch2");
    wr(4'd14, 8'hB7, "R5 staged low ch3");
    wr(4'd2,  8'h00, "R7 back to immediate");
    wr(4'd15, 8'h0E, "R4 immediate after return ch3");
    wr(4'd2,  8'h80, "R6 second transfer");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_immediate();
    t_stray();
    t_sync();
    t_sync_again();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule